// File: doc/BRIEF.md
# Radio Frame Timestamp Unit

This block sits between a bit-serial radio datapath and the software that handles frames, and it pins down when each frame happened in local time. On the receive side it watches the incoming bit stream for a programmed 16-bit sync word. Once the word is seen, it packs the bits that follow into bytes and writes them into a 16-entry byte queue. In the cycle in which the first byte of the frame lands in the queue, it copies the free-running local time into a capture register and raises a one-cycle interrupt pulse. The capture point is the same on every frame, so the receive latency is a fixed, known constant.

On the transmit side, a channel-clear pulse arms the block and freezes the local time. The payload bytes then stream through. The four timestamp bytes overwrite the payload at a configurable byte position, least significant byte first. The block then appends a CRC-16 that covers the bytes it actually sent, so the checksum always includes the inserted time. Frames that carry a timestamp have a fixed length, which makes the delay from channel-clear to the end of the CRC deterministic.

If a byte arrives while the queue is full and nothing is being read, the frame is dropped. The queue is emptied, the captured time is marked invalid, a sticky error flag is set, and the block returns to searching for the sync word.

Top module: `frame_ts_unit`

## Requirements
- R1: While searching, a frame starts on the cycle in which the 16 most recent valid bits, oldest as bit 15 and newest as bit 0, equal `sync_word` exactly. At least 16 valid bits must have arrived since searching began, so bits left over from the previous frame never complete a match.
- R2: After a match, valid bits are packed most significant bit first. Each eighth bit writes one byte into the queue on that clock edge. After `rx_len` bytes (1 to 31) the block returns to searching.
- R3: The queue holds up to 16 bytes in order. `fifo_rd_data` always shows the oldest byte. `fifo_rd` removes that byte when the queue is not empty. `fifo_count` gives the occupancy and changes only on a write, a read or a drop.
- R4: On the clock edge that writes the first byte of a frame, `rx_ts` takes the `local_time` value present at that edge and `rx_ts_valid` goes to 1. `rx_irq` is high for exactly the one following cycle.
- R5: A byte that completes while the queue holds 16 bytes and `fifo_rd` is low drops the frame. `fifo_count` becomes 0, `rx_ts_valid` becomes 0, `rx_overflow_err` becomes 1, and the block returns to searching. The error flag stays set until reset.
- R6: A `tx_cca` pulse while transmit is idle latches `local_time` and arms the transmitter. Output bytes at index `ts_offset` to `ts_offset`+3 (index 0 is the first byte) are the latched time's bits [7:0], [15:8], [23:16] and [31:24], in place of the input bytes.
- R7: Each accepted input byte appears on `tx_out_byte` with `tx_out_valid` high one cycle later. After the `tx_len`-th byte, the CRC high byte and then the CRC low byte follow on the next two cycles.
- R8: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed over the emitted payload bytes (timestamp included), most significant bit first, with no reflection and no final inversion.
- R9: Input bytes presented while transmit is idle, or during the two CRC cycles, produce no payload output and are not counted. `tx_cca` has no effect while a frame is in progress.
- R10: Reset leaves the queue empty, `rx_irq`, `rx_ts_valid`, `rx_overflow_err` and `tx_out_valid` at 0, and both paths idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_time | input | 32 | Free-running local time value |
| sync_word | input | 16 | Programmed receive sync word |
| rx_len | input | 5 | Receive frame length in bytes |
| rx_bit_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received bit |
| fifo_rd | input | 1 | Remove the oldest queued byte |
| fifo_rd_data | output | 8 | Oldest queued byte |
| fifo_count | output | 5 | Queue occupancy |
| rx_irq | output | 1 | One-cycle pulse when the first byte is queued |
| rx_ts | output | 32 | Captured receive time |
| rx_ts_valid | output | 1 | Captured time belongs to a kept frame |
| rx_overflow_err | output | 1 | Sticky frame-drop flag |
| tx_cca | input | 1 | Channel-clear pulse, arms transmit |
| tx_len | input | 5 | Transmit payload length in bytes |
| ts_offset | input | 5 | Byte index of the timestamp in the payload |
| tx_in_valid | input | 1 | Payload byte strobe |
| tx_in_byte | input | 8 | Payload byte |
| tx_out_valid | output | 1 | Output byte strobe |
| tx_out_byte | output | 8 | Payload byte with timestamp, then CRC |

## Verification
The hardest case to reach from the ports is a sync word that would appear only if stale shift-register contents were counted. To reach it, the bench ends a frame whose last data bytes form most of the sync word, then sends the single bit that would complete it, and checks that nothing is queued. Overflow is reached by sending a frame longer than the queue while `fifo_rd` is held low, and a second frame then shows that the block recovers while the error flag stays set. On transmit, the bench sweeps the timestamp position across every legal offset, adds input gaps and late bytes during the CRC cycles, and checks every output byte against a CRC it computes itself.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int SYNC_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int TS_W    = 32;
    localparam int TS_NB   = TS_W / BYTE_W;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_BODY,
        TXS_CRC_HI,
        TXS_CRC_LO
    } txs_e;

    // One byte of CRC-16, most significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ data[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/fts_sync_detect.sv
module fts_sync_detect #(
    parameter int SYNC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              searching,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [SYNC_W-1:0] pattern,
    output logic              hit
);
    localparam int CW = $clog2(SYNC_W);

    logic [SYNC_W-2:0] hist;
    logic [CW-1:0]     seen;
    logic              primed;

    assign primed = (seen == CW'(SYNC_W - 1));
    assign hit    = searching && bit_valid && primed && ({hist, bit_in} == pattern);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            seen <= '0;
        end else begin
            if (bit_valid) hist <= {hist[SYNC_W-3:0], bit_in};
            if (!searching)                  seen <= '0;
            else if (bit_valid && !primed)   seen <= seen + CW'(1);
        end
    end
endmodule

// File: rtl/fts_rx_framer.sv
module fts_rx_framer #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             q_full,
    input  logic             q_rd,
    output logic             searching,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             first_wr,
    output logic             drop
);
    logic             in_frame;
    logic [2:0]       bitcnt;
    logic [LEN_W-1:0] bytecnt;
    logic [6:0]       acc;
    logic             byte_done;

    assign searching = !in_frame;
    assign byte_done = in_frame && bit_valid && (bitcnt == 3'd7);
    assign wr_data   = {acc, bit_in};
    assign drop      = byte_done && q_full && !q_rd;
    assign wr_en     = byte_done && !drop;
    assign first_wr  = wr_en && (bytecnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            bitcnt   <= '0;
            bytecnt  <= '0;
            acc      <= '0;
        end else if (hit) begin
            in_frame <= 1'b1;
            bitcnt   <= '0;
            bytecnt  <= '0;
        end else if (in_frame && bit_valid) begin
            acc    <= {acc[5:0], bit_in};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
                bytecnt <= bytecnt + LEN_W'(1);
                if (drop || (bytecnt + LEN_W'(1) == rx_len)) in_frame <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fts_byte_queue.sv
module fts_byte_queue #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_req,
    input  logic          flush,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          rd_en;

    assign full    = (count == CW'(DEPTH));
    assign rd_en   = rd_req && (count != '0);
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_en) wp <= wp + AW'(1);
            if (rd_en) rp <= rp + AW'(1);
            case ({wr_en, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fts_tx_stamp.sv
module fts_tx_stamp
    import fts_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TS_W-1:0]  local_time,
    input  logic             cca,
    input  logic [LEN_W-1:0] tx_len,
    input  logic [LEN_W-1:0] ts_offset,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [7:0]       out_byte
);
    txs_e             state;
    logic [LEN_W-1:0] idx;
    logic [TS_W-1:0]  ts_hold;
    logic [15:0]      crc;
    logic [LEN_W:0]   rel;
    logic             in_ts;
    logic [TS_W-1:0]  ts_shift;
    logic [7:0]       eff_byte;

    assign rel      = {1'b0, idx} - {1'b0, ts_offset};
    assign in_ts    = (idx >= ts_offset) && (rel < (LEN_W+1)'(TS_NB));
    assign ts_shift = ts_hold >> {rel[1:0], 3'b000};
    assign eff_byte = in_ts ? ts_shift[7:0] : in_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TXS_IDLE;
            idx       <= '0;
            ts_hold   <= '0;
            crc       <= CRC_SEED;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                TXS_IDLE: if (cca) begin
                    ts_hold <= local_time;
                    idx     <= '0;
                    crc     <= CRC_SEED;
                    state   <= TXS_BODY;
                end
                TXS_BODY: if (in_valid) begin
                    out_byte  <= eff_byte;
                    out_valid <= 1'b1;
                    crc       <= crc16_byte(crc, eff_byte);
                    idx       <= idx + LEN_W'(1);
                    if (idx + LEN_W'(1) == tx_len) state <= TXS_CRC_HI;
                end
                TXS_CRC_HI: begin
                    out_byte  <= crc[15:8];
                    out_valid <= 1'b1;
                    state     <= TXS_CRC_LO;
                end
                default: begin
                    out_byte  <= crc[7:0];
                    out_valid <= 1'b1;
                    state     <= TXS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/frame_ts_unit.sv
module frame_ts_unit
    import fts_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LEN_W  = 5,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   local_time,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_bit_valid,
    input  logic              rx_bit,
    input  logic              fifo_rd,
    output logic [7:0]        fifo_rd_data,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              rx_irq,
    output logic [TS_W-1:0]   rx_ts,
    output logic              rx_ts_valid,
    output logic              rx_overflow_err,
    input  logic              tx_cca,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [LEN_W-1:0]  ts_offset,
    input  logic              tx_in_valid,
    input  logic [7:0]        tx_in_byte,
    output logic              tx_out_valid,
    output logic [7:0]        tx_out_byte
);
    logic       searching, hit;
    logic       wr_en, first_wr, ovf_flush, q_full;
    logic [7:0] wr_data;

    fts_sync_detect #(.SYNC_W(SYNC_W)) u_sync (
        .clk(clk), .rst(rst), .searching(searching),
        .bit_valid(rx_bit_valid), .bit_in(rx_bit),
        .pattern(sync_word), .hit(hit)
    );

    fts_rx_framer #(.LEN_W(LEN_W)) u_framer (
        .clk(clk), .rst(rst), .hit(hit),
        .bit_valid(rx_bit_valid), .bit_in(rx_bit), .rx_len(rx_len),
        .q_full(q_full), .q_rd(fifo_rd), .searching(searching),
        .wr_en(wr_en), .wr_data(wr_data), .first_wr(first_wr), .drop(ovf_flush)
    );

    fts_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(fifo_rd), .flush(ovf_flush), .rd_data(fifo_rd_data),
        .count(fifo_count), .full(q_full)
    );

    fts_tx_stamp #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .local_time(local_time), .cca(tx_cca),
        .tx_len(tx_len), .ts_offset(ts_offset), .in_valid(tx_in_valid),
        .in_byte(tx_in_byte), .out_valid(tx_out_valid), .out_byte(tx_out_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_irq          <= 1'b0;
            rx_ts           <= '0;
            rx_ts_valid     <= 1'b0;
            rx_overflow_err <= 1'b0;
        end else begin
            rx_irq <= first_wr;
            if (first_wr) begin
                rx_ts       <= local_time;
                rx_ts_valid <= 1'b1;
            end else if (ovf_flush) begin
                rx_ts_valid <= 1'b0;
            end
            if (ovf_flush) rx_overflow_err <= 1'b1;
        end
    end
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_bit_valid,
    input logic             fifo_rd,
    input logic [CNT_W-1:0] fifo_count,
    input logic             rx_irq,
    input logic             rx_ts_valid,
    input logic             rx_overflow_err,
    input logic             ovf_flush
);
    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!rx_bit_valid && !fifo_rd) |=> $stable(fifo_count));

    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    assert_irq_stamp_R4: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_ts_valid);

    assert_drop_state_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_flush |=> (fifo_count == '0 && !rx_ts_valid && rx_overflow_err));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        rx_overflow_err |=> rx_overflow_err);
endmodule

bind frame_ts_unit fts_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rx_bit_valid(rx_bit_valid), .fifo_rd(fifo_rd),
    .fifo_count(fifo_count), .rx_irq(rx_irq), .rx_ts_valid(rx_ts_valid),
    .rx_overflow_err(rx_overflow_err), .ovf_flush(ovf_flush)
);

// File: tb/frame_ts_unit_tb.sv
`timescale 1ns/1ps
module frame_ts_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] local_time = 32'h1000_0000;
    logic [15:0] sync_word = 16'hFFFE;
    logic [4:0]  rx_len = 5'd1;
    logic        rx_bit_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        fifo_rd = 1'b0;
    logic [7:0]  fifo_rd_data;
    logic [4:0]  fifo_count;
    logic        rx_irq;
    logic [31:0] rx_ts;
    logic        rx_ts_valid;
    logic        rx_overflow_err;
    logic        tx_cca = 1'b0;
    logic [4:0]  tx_len = 5'd8;
    logic [4:0]  ts_offset = 5'd0;
    logic        tx_in_valid = 1'b0;
    logic [7:0]  tx_in_byte = 8'h00;
    logic        tx_out_valid;
    logic [7:0]  tx_out_byte;

    int tests = 0;
    int fails = 0;
    int bit_no = 0;
    int irq_hits = 0;
    int irq_bit = 0;
    logic [31:0] irq_time = '0;
    logic [7:0]  frm [0:31];
    bit done = 0;

    always #5 clk = ~clk;
    always @(negedge clk) local_time <= local_time + 32'h0103_0507;

    frame_ts_unit u_dut (
        .clk(clk), .rst(rst), .local_time(local_time), .sync_word(sync_word),
        .rx_len(rx_len), .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
        .fifo_rd(fifo_rd), .fifo_rd_data(fifo_rd_data), .fifo_count(fifo_count),
        .rx_irq(rx_irq), .rx_ts(rx_ts), .rx_ts_valid(rx_ts_valid),
        .rx_overflow_err(rx_overflow_err), .tx_cca(tx_cca), .tx_len(tx_len),
        .ts_offset(ts_offset), .tx_in_valid(tx_in_valid), .tx_in_byte(tx_in_byte),
        .tx_out_valid(tx_out_valid), .tx_out_byte(tx_out_byte)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit_valid = 1'b1;
        rx_bit = b;
        @(posedge clk); #1;
        bit_no++;
        if (rx_irq) begin
            irq_hits++;
            irq_bit = bit_no;
            irq_time = local_time;
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_bit_valid = 1'b0;
    endtask

    // noise, near-miss word, sync word, then nbytes of frm[]
    task automatic send_frame(input logic [15:0] noise, input logic [15:0] near,
                              input int nbytes);
        logic [4:0] c0;
        int start;
        send_word(noise);
        c0 = fifo_count;
        send_word(near);
        chk(fifo_count == c0, "R1", "near-miss sync word queued bytes", 32'(fifo_count), 32'(c0));
        irq_hits = 0;
        send_word(sync_word);
        start = bit_no;
        for (int j = 0; j < nbytes; j++)
            for (int i = 7; i >= 0; i--) send_bit(frm[j][i]);
        chk(irq_hits == 1 && irq_bit == start + 8, "R4", "irq pulse bit position",
            32'(irq_bit), 32'(start + 8));
    endtask

    task automatic pop_all(input int n, input string req);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(fifo_rd_data == frm[j], req, "queued byte", 32'(fifo_rd_data), 32'(frm[j]));
            fifo_rd = 1'b1;
        end
        @(negedge clk);
        fifo_rd = 1'b0;
        chk(fifo_count == 0, "R3", "queue empty after reads", 32'(fifo_count), 0);
    endtask

    task automatic tx_frame(input int len, input int ofs, input int seed, input int gap_at);
        logic [31:0] ts_exp;
        logic [15:0] crc;
        logic [7:0]  din, dexp;
        int bad;
        tx_len = 5'(len);
        ts_offset = 5'(ofs);
        @(negedge clk); tx_cca = 1'b1;
        @(posedge clk); #1; ts_exp = local_time;
        @(negedge clk); tx_cca = 1'b0;
        crc = 16'hFFFF;
        bad = 0;
        for (int i = 0; i < len; i++) begin
            if (i == gap_at) begin
                @(negedge clk); tx_in_valid = 1'b0; tx_cca = 1'b1;
                @(posedge clk); #1;
                chk(!tx_out_valid, "R9", "output during input gap", 32'(tx_out_valid), 0);
                @(negedge clk); tx_cca = 1'b0;
            end else begin
                @(negedge clk);
            end
            din = 8'(seed + i * 29);
            tx_in_valid = 1'b1;
            tx_in_byte = din;
            @(posedge clk); #1;
            dexp = (i >= ofs && i < ofs + 4) ? 8'(ts_exp >> (8 * (i - ofs))) : din;
            crc = ref_crc(crc, dexp);
            if (!(tx_out_valid && tx_out_byte == dexp)) begin
                bad++;
                chk(0, (i >= ofs && i < ofs + 4) ? "R6" : "R7", "payload byte",
                    {23'd0, tx_out_valid, tx_out_byte}, {24'd1, dexp});
            end
        end
        chk(bad == 0, "R6", "payload with timestamp intact", 32'(bad), 0);
        @(negedge clk); tx_in_byte = 8'h5A;
        @(posedge clk); #1;
        chk(tx_out_valid && tx_out_byte == crc[15:8], "R8", "CRC high byte",
            {23'd0, tx_out_valid, tx_out_byte}, {24'd1, crc[15:8]});
        @(posedge clk); #1;
        chk(tx_out_valid && tx_out_byte == crc[7:0], "R8", "CRC low byte",
            {23'd0, tx_out_valid, tx_out_byte}, {24'd1, crc[7:0]});
        @(posedge clk); #1;
        chk(!tx_out_valid, "R9", "late byte after CRC ignored", 32'(tx_out_valid), 0);
        @(negedge clk); tx_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R10 reset state
        chk(fifo_count == 0 && !rx_irq && !rx_ts_valid && !rx_overflow_err && !tx_out_valid,
            "R10", "reset state", {fifo_count, rx_irq, rx_ts_valid, rx_overflow_err, tx_out_valid}, 0);

        // R1/R2/R3/R4: sync FFFE, 5-byte frame
        sync_word = 16'hFFFE; rx_len = 5'd5;
        for (int j = 0; j < 32; j++) frm[j] = 8'((j * 8'h4B) ^ 8'hC3);
        send_frame(16'h0000, 16'hFFFF, 5);
        rx_idle();
        chk(rx_ts == irq_time && rx_ts_valid, "R4", "captured time", rx_ts, irq_time);
        chk(fifo_count == 5, "R2", "frame byte count", 32'(fifo_count), 5);
        pop_all(5, "R2");

        // sync 0001, full 16-byte frame fills the queue exactly
        sync_word = 16'h0001; rx_len = 5'd16;
        for (int j = 0; j < 32; j++) frm[j] = 8'(j * 8'h3D + 8'h11);
        send_frame(16'hFFFF, 16'h0000, 16);
        rx_idle();
        chk(fifo_count == 16 && !rx_overflow_err, "R3", "full queue without drop",
            32'(fifo_count), 16);
        chk(rx_ts == irq_time, "R4", "captured time second frame", rx_ts, irq_time);
        pop_all(16, "R3");

        // R1: stale bits from the frame must not complete the sync word
        sync_word = 16'hFFFE; rx_len = 5'd2;
        frm[0] = 8'hFF; frm[1] = 8'hFF;
        send_frame(16'h0000, 16'hFFFF, 2);
        send_bit(1'b0);
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        rx_idle();
        chk(fifo_count == 2 && irq_hits == 1, "R1", "no match on stale history",
            32'(fifo_count), 2);
        pop_all(2, "R1");

        // R5: overflow with 17 bytes of a 20-byte frame and no reads
        rx_len = 5'd20;
        for (int j = 0; j < 32; j++) frm[j] = 8'h00;
        send_frame(16'h0000, 16'hFFFF, 16);
        chk(fifo_count == 16 && rx_ts_valid, "R5", "queue full before drop",
            32'(fifo_count), 16);
        for (int i = 7; i >= 0; i--) send_bit(1'b0);
        rx_idle();
        chk(fifo_count == 0 && !rx_ts_valid && rx_overflow_err, "R5", "frame dropped",
            {fifo_count, rx_ts_valid, rx_overflow_err}, {5'd0, 2'b01});

        // recovery; error flag stays set
        rx_len = 5'd3;
        frm[0] = 8'h81; frm[1] = 8'h7E; frm[2] = 8'h24;
        send_frame(16'h0000, 16'hFFFF, 3);
        rx_idle();
        chk(fifo_count == 3 && rx_ts_valid && rx_overflow_err, "R5", "recovery with sticky flag",
            {fifo_count, rx_ts_valid, rx_overflow_err}, {5'd3, 2'b11});
        pop_all(3, "R2");

        // R9: bytes while idle are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tx_in_valid = 1'b1; tx_in_byte = 8'(i + 1);
            @(posedge clk); #1;
            chk(!tx_out_valid, "R9", "byte while idle", 32'(tx_out_valid), 0);
        end
        @(negedge clk); tx_in_valid = 1'b0;

        // R6/R7/R8: sweep the timestamp position over an 8-byte payload
        for (int o = 0; o <= 4; o++) tx_frame(8, o, o * 17 + 3, (o == 2) ? 3 : -1);
        tx_frame(12, 8, 77, 5);
        tx_frame(4, 0, 9, -1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule